// File: doc/BRIEF.md
# Tick-Sequenced Accumulator Processor

This block is a small 8-bit accumulator computer with its own 16-word store. Every instruction word holds a 4-bit operation code in its upper half and a 4-bit address in its lower half. A tick counter steps the machine through one register transfer per clock. The first three ticks fetch the instruction. The ticks after that carry out the operation. When the operation's last transfer completes, the counter returns to the first tick.

All memory traffic passes through an address register and a data buffer register. Sums and differences are built in a private addend register before they reach the accumulator. The control strobes are sums of products: each product is a one-hot tick line ANDed with a one-hot opcode line. A preload port lets the environment fill the store, normally while reset is held. Debug outputs show the program counter, the accumulator and whether the machine has stopped.

Top module: `acc_seq_core`

## Requirements
- R1: While reset is asserted, and right after it is released, the program counter and accumulator read 0, the tick counter is at the first tick and the halted flag is low.
- R2: Bits 7:4 of an instruction are the opcode and bits 3:0 the address. Fetch takes three clocks. Opcode 1 (load direct) copies the addressed word into the accumulator and takes 6 clocks in total.
- R3: Opcode 5 (add) sets the accumulator to the addressed word plus the accumulator, modulo 256, in 8 clocks.
- R4: Opcode 6 (subtract) sets the accumulator to the addressed word minus the accumulator, modulo 256, in 8 clocks.
- R5: Opcode 2 (load indirect) reads the word at the given address. It uses that word's low 4 bits as a second address and loads the accumulator from there, in 8 clocks.
- R6: Opcode 3 (store direct) writes the accumulator to the given address in 5 clocks.
- R7: Opcode 4 (store indirect) writes the accumulator to the address held in the low 4 bits of the word at the given address, in 7 clocks. The pointer word itself is unchanged.
- R8: Opcode 7 (jump) sets the program counter to the address field in 5 clocks. As a side effect it leaves the address field, zero-extended, in the accumulator.
- R9: Opcode 8 (jump if zero) loads the address field into the program counter only when the accumulator is 0. It never changes the accumulator and takes 4 clocks.
- R10: Opcode 0 stops the machine 3 clocks after its fetch begins. The program counter then points past it, and the halted flag, program counter and accumulator stay frozen until reset.
- R11: Opcodes 9 to 15 change nothing but the program counter and take 4 clocks.
- R12: The program counter wraps from 15 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pre_we | input | 1 | Preload write enable for the store |
| pre_addr | input | 4 | Preload word address |
| pre_data | input | 8 | Preload word value |
| dbg_pc | output | 4 | Current program counter |
| dbg_ac | output | 8 | Current accumulator |
| dbg_halted | output | 1 | High while the machine is stopped on opcode 0 |

## Verification
The bench targets the subtract operand order: a design that computes accumulator minus memory returns 0x02 where 0xFE is expected. It checks that the jump overwrites the accumulator, and that the conditional jump does so neither when taken nor when not taken. It also tests modulo-256 carry loss on add. A wrap test runs a store at address 15 that rewrites address 0 into a halt, so the test only finishes correctly if the counter wraps to 0. Per-program clock counts catch a sequence that ends a tick early or late. Indirect load and store are run with pointers that differ from their own addresses, which exposes a design that skips the second indirection.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_HLT = 4'd0, OP_LDA = 4'd1, OP_LDI = 4'd2, OP_STA = 4'd3,
    OP_STI = 4'd4, OP_ADD = 4'd5, OP_SUB = 4'd6, OP_JMP = 4'd7,
    OP_JMZ = 4'd8
  } opcode_e;

  typedef enum logic [1:0] {MAR_FROM_PC, MAR_FROM_OPND, MAR_FROM_MBR} mar_sel_e;
  typedef enum logic [1:0] {AC_FROM_MBR, AC_FROM_AD, AC_FROM_OPND} ac_sel_e;
  typedef enum logic {PC_FROM_OPND, PC_FROM_AC} pc_sel_e;
  typedef enum logic {AD_FROM_MBR, AD_FROM_ALU} ad_sel_e;

  typedef struct packed {
    logic     mar_ld;
    mar_sel_e mar_sel;
    logic     mbr_ld;
    logic     ir_ld;
    logic     pc_inc;
    logic     pc_ld;
    pc_sel_e  pc_sel;
    logic     ac_ld;
    ac_sel_e  ac_sel;
    logic     ad_ld;
    ad_sel_e  ad_sel;
    logic     alu_sub;
    logic     mem_we;
    logic     t_inc;
    logic     t_clr;
  } ctrl_t;

endpackage

// File: rtl/acc_seq_timer.sv
module acc_seq_timer #(
  parameter int NUM_TICKS = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 t_inc,
  input  logic                 t_clr,
  output logic [NUM_TICKS-1:0] tick_oh
);
  localparam int CNT_W = $clog2(NUM_TICKS);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (t_clr) cnt <= '0;
    else if (t_inc) cnt <= cnt + 1'b1;
  end

  for (genvar i = 0; i < NUM_TICKS; i++) begin : g_tick
    assign tick_oh[i] = (cnt == CNT_W'(i));
  end
endmodule

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
  import acc_seq_pkg::*;
#(
  parameter int NUM_TICKS = 10
) (
  input  logic [NUM_TICKS-1:0] tick_oh,
  input  logic [OP_W-1:0]      op,
  input  logic                 ac_zero,
  output ctrl_t                c,
  output logic                 halted
);
  localparam int NUM_OPS = 1 << OP_W;

  logic [NUM_OPS-1:0] q;
  logic [NUM_TICKS-1:0] t;
  logic mem_op, via_ptr, arith, nop, last;

  assign t = tick_oh;

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_opline
    assign q[k] = (op == OP_W'(k));
  end

  assign mem_op  = q[OP_LDA] | q[OP_LDI] | q[OP_STA] | q[OP_STI] | q[OP_ADD] | q[OP_SUB];
  assign via_ptr = q[OP_LDI] | q[OP_STI];
  assign arith   = q[OP_ADD] | q[OP_SUB];
  assign nop     = |q[NUM_OPS-1:OP_JMZ+1];

  assign last = (t[5] & q[OP_LDA])
              | (t[7] & (q[OP_LDI] | arith))
              | (t[4] & (q[OP_STA] | q[OP_JMP]))
              | (t[6] & q[OP_STI])
              | (t[3] & (q[OP_JMZ] | nop));

  assign halted = t[3] & q[OP_HLT];

  always_comb begin
    c = '0;
    c.mar_ld  = t[0] | (t[3] & mem_op) | (t[5] & via_ptr);
    c.mar_sel = t[0] ? MAR_FROM_PC : (t[3] ? MAR_FROM_OPND : MAR_FROM_MBR);
    c.mbr_ld  = t[1] | (t[4] & mem_op & ~q[OP_STA]) | (t[6] & q[OP_LDI]);
    c.ir_ld   = t[2];
    c.pc_inc  = t[1];
    c.pc_ld   = (t[4] & q[OP_JMP]) | (t[3] & q[OP_JMZ] & ac_zero);
    c.pc_sel  = q[OP_JMP] ? PC_FROM_AC : PC_FROM_OPND;
    c.ac_ld   = (t[5] & q[OP_LDA]) | (t[7] & (q[OP_LDI] | arith)) | (t[3] & q[OP_JMP]);
    c.ac_sel  = q[OP_JMP] ? AC_FROM_OPND : (arith ? AC_FROM_AD : AC_FROM_MBR);
    c.ad_ld   = (t[5] | t[6]) & arith;
    c.ad_sel  = t[6] ? AD_FROM_ALU : AD_FROM_MBR;
    c.alu_sub = q[OP_SUB];
    c.mem_we  = (t[4] & q[OP_STA]) | (t[6] & q[OP_STI]);
    c.t_clr   = last;
    c.t_inc   = ~last & ~halted;
  end
endmodule

// File: rtl/acc_seq_mem.sv
module acc_seq_mem #(
  parameter int WORD_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              pre_we,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [WORD_W-1:0] pre_data,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] store [DEPTH];

  assign rdata = store[addr];

  always_ff @(posedge clk) begin
    if (pre_we)  store[pre_addr] <= pre_data;
    else if (we) store[addr] <= wdata;
  end
endmodule

// File: rtl/acc_seq_alu.sv
module acc_seq_alu #(
  parameter int WORD_W = 8
) (
  input  logic [WORD_W-1:0] lhs,
  input  logic [WORD_W-1:0] rhs,
  input  logic              sub,
  output logic [WORD_W-1:0] res
);
  function automatic logic [WORD_W-1:0] wrap_add(input logic [WORD_W-1:0] a, b);
    return a + b;
  endfunction

  function automatic logic [WORD_W-1:0] wrap_sub(input logic [WORD_W-1:0] a, b);
    return a - b;
  endfunction

  assign res = sub ? wrap_sub(lhs, rhs) : wrap_add(lhs, rhs);
endmodule

// File: rtl/acc_seq_core.sv
module acc_seq_core
  import acc_seq_pkg::*;
#(
  parameter int WORD_W    = 8,
  parameter int ADDR_W    = 4,
  parameter int NUM_TICKS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pre_we,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [WORD_W-1:0] pre_data,
  output logic [ADDR_W-1:0] dbg_pc,
  output logic [WORD_W-1:0] dbg_ac,
  output logic              dbg_halted
);
  localparam int OPND_LSB = 0;
  localparam int OP_LSB   = WORD_W - OP_W;

  logic [ADDR_W-1:0]    pc, mar;
  logic [WORD_W-1:0]    ir, mbr, ac, ad;
  logic [WORD_W-1:0]    mem_rd, alu_y;
  logic [ADDR_W-1:0]    opnd;
  logic [OP_W-1:0]      ir_op;
  logic [NUM_TICKS-1:0] tick_oh;
  logic                 halted;
  ctrl_t                c;

  assign opnd  = ir[OPND_LSB +: ADDR_W];
  assign ir_op = ir[OP_LSB +: OP_W];

  acc_seq_timer #(.NUM_TICKS(NUM_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .t_inc(c.t_inc), .t_clr(c.t_clr), .tick_oh(tick_oh)
  );

  acc_seq_ctrl #(.NUM_TICKS(NUM_TICKS)) u_ctrl (
    .tick_oh(tick_oh), .op(ir_op), .ac_zero(ac == '0), .c(c), .halted(halted)
  );

  acc_seq_mem #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data),
    .we(c.mem_we), .addr(mar), .wdata(ac), .rdata(mem_rd)
  );

  acc_seq_alu #(.WORD_W(WORD_W)) u_alu (
    .lhs(ad), .rhs(ac), .sub(c.alu_sub), .res(alu_y)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc  <= '0;
      mar <= '0;
      ir  <= '0;
      mbr <= '0;
      ac  <= '0;
      ad  <= '0;
    end else begin
      if (c.mar_ld) begin
        case (c.mar_sel)
          MAR_FROM_PC:   mar <= pc;
          MAR_FROM_OPND: mar <= opnd;
          default:       mar <= mbr[ADDR_W-1:0];
        endcase
      end
      if (c.mbr_ld) mbr <= mem_rd;
      if (c.ir_ld)  ir  <= mbr;
      if (c.pc_inc)     pc <= pc + 1'b1;
      else if (c.pc_ld) pc <= (c.pc_sel == PC_FROM_AC) ? ac[ADDR_W-1:0] : opnd;
      if (c.ac_ld) begin
        case (c.ac_sel)
          AC_FROM_OPND: ac <= WORD_W'(opnd);
          AC_FROM_AD:   ac <= ad;
          default:      ac <= mbr;
        endcase
      end
      if (c.ad_ld) ad <= (c.ad_sel == AD_FROM_ALU) ? alu_y : mbr;
    end
  end

  assign dbg_pc     = pc;
  assign dbg_ac     = ac;
  assign dbg_halted = halted;
endmodule

// File: rtl/acc_seq_checker.sv
module acc_seq_checker #(
  parameter int WORD_W    = 8,
  parameter int ADDR_W    = 4,
  parameter int NUM_TICKS = 10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_TICKS-1:0] tick_oh,
  input logic                 halted,
  input logic [ADDR_W-1:0]    pc,
  input logic [WORD_W-1:0]    ac,
  input logic [3:0]           ir_op,
  input logic                 mem_we,
  input logic                 pc_inc
);
  p_tick_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tick_oh) == 1);

  p_fetch_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_oh[0] |=> tick_oh[1]);

  p_pc_wrap_inc_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pc_inc |=> pc == ADDR_W'($past(pc) + 1'b1));

  p_halt_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(pc) && $stable(ac));

  p_jmz_keeps_ac_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_oh[3] && ir_op == 4'd8) |=> $stable(ac));

  p_write_in_exec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (tick_oh[4] || tick_oh[6]));
endmodule

bind acc_seq_core acc_seq_checker #(
  .WORD_W(WORD_W), .ADDR_W(ADDR_W), .NUM_TICKS(NUM_TICKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_oh(tick_oh), .halted(halted), .pc(pc),
  .ac(ac), .ir_op(ir_op), .mem_we(c.mem_we), .pc_inc(c.pc_inc)
);

// File: tb/test_acc_seq_core.sv
module test_acc_seq_core;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_LIMIT  = 400;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pre_we = 1'b0;
  logic [3:0] pre_addr = '0;
  logic [7:0] pre_data = '0;
  logic [3:0] dbg_pc;
  logic [7:0] dbg_ac;
  logic       dbg_halted;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] img [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_seq_core i_acc_seq_core (
    .clk(clk), .rst_n(rst_n), .pre_we(pre_we), .pre_addr(pre_addr),
    .pre_data(pre_data), .dbg_pc(dbg_pc), .dbg_ac(dbg_ac), .dbg_halted(dbg_halted)
  );

  // clocks per instruction, from the requirements
  function automatic int cost(input logic [3:0] op);
    case (op)
      4'd0: return 3;
      4'd1: return 6;
      4'd2, 4'd5, 4'd6: return 8;
      4'd3, 4'd7: return 5;
      4'd4: return 7;
      default: return 4;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_img();
    for (int i = 0; i < 16; i++) img[i] = 8'h00;
  endtask

  // hold reset, preload the store, release on a falling edge
  task automatic boot();
    rst_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      pre_we = 1'b1; pre_addr = 4'(i); pre_data = img[i];
      @(negedge clk);
    end
    pre_we = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic run(output int cyc);
    cyc = 0;
    while (!dbg_halted && cyc < RUN_LIMIT) begin
      @(posedge clk); @(negedge clk);
      cyc++;
    end
  endtask

  task automatic t_reset();
    int cyc;
    clear_img();
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 pc in reset", dbg_pc, 0);
    check("R1 ac in reset", dbg_ac, 0);
    check("R1 halted in reset", dbg_halted, 0);
    boot();
    #1;
    check("R1 pc after release", dbg_pc, 0);
    check("R1 halted after release", dbg_halted, 0);
    run(cyc);
    check("R10 halt clocks", cyc, cost(0));
    check("R10 pc past halt", dbg_pc, 1);
    repeat (20) @(negedge clk);
    check("R10 still halted", dbg_halted, 1);
    check("R10 pc frozen", dbg_pc, 1);
    check("R10 ac frozen", dbg_ac, 0);
  endtask

  task automatic t_lda_add_sta();
    int cyc;
    clear_img();
    img[0] = 8'h1A; img[1] = 8'h5B; img[2] = 8'h3C; img[3] = 8'h1D;
    img[4] = 8'h1C; img[5] = 8'h00;
    img[10] = 8'h25; img[11] = 8'h17;
    boot(); run(cyc);
    check("R3 R6 stored sum reloaded", dbg_ac, 8'h3C);
    check("R6 program pc", dbg_pc, 6);
    check("R2 R3 R6 clocks", cyc, cost(1)*3 + cost(5) + cost(3) + cost(0));
  endtask

  task automatic t_lda_timing();
    int cyc;
    clear_img();
    img[0] = 8'h1F; img[15] = 8'hA5;
    boot(); run(cyc);
    check("R2 lda value", dbg_ac, 8'hA5);
    check("R2 lda clocks", cyc, cost(1) + cost(0));
  endtask

  task automatic t_add_wrap();
    int cyc;
    clear_img();
    img[0] = 8'h1E; img[1] = 8'h5F; img[14] = 8'hF0; img[15] = 8'h20;
    boot(); run(cyc);
    check("R3 add wraps mod 256", dbg_ac, 8'h10);
    check("R3 add clocks", cyc, cost(1) + cost(5) + cost(0));
  endtask

  task automatic t_sub_order();
    int cyc;
    clear_img();
    img[0] = 8'h1E; img[1] = 8'h6F; img[14] = 8'h05; img[15] = 8'h03;
    boot(); run(cyc);
    check("R4 mem minus ac", dbg_ac, 8'hFE);
    check("R4 sub clocks", cyc, cost(1) + cost(6) + cost(0));
  endtask

  task automatic t_ldi();
    int cyc;
    clear_img();
    img[0] = 8'h2A; img[10] = 8'h3C; img[12] = 8'h77;
    boot(); run(cyc);
    check("R5 indirect load", dbg_ac, 8'h77);
    check("R5 ldi clocks", cyc, cost(2) + cost(0));
  endtask

  task automatic t_sti();
    int cyc;
    clear_img();
    img[0] = 8'h1D; img[1] = 8'h4A; img[2] = 8'h1B; img[3] = 8'h1E;
    img[4] = 8'h00; img[10] = 8'h0E; img[13] = 8'h99;
    boot(); run(cyc);
    check("R7 indirect store target", dbg_ac, 8'h99);
    check("R7 sti clocks", cyc, cost(1)*3 + cost(4) + cost(0));
    clear_img();
    img[0] = 8'h1D; img[1] = 8'h4A; img[2] = 8'h1A; img[3] = 8'h00;
    img[10] = 8'h0E; img[13] = 8'h99;
    boot(); run(cyc);
    check("R7 pointer unchanged", dbg_ac, 8'h0E);
  endtask

  task automatic t_jmp();
    int cyc;
    clear_img();
    img[0] = 8'h7A; img[1] = 8'h1F; img[15] = 8'h55;
    boot(); run(cyc);
    check("R8 jump target pc", dbg_pc, 11);
    check("R8 ac holds operand", dbg_ac, 8'h0A);
    check("R8 jmp clocks", cyc, cost(7) + cost(0));
  endtask

  task automatic t_jmz();
    int cyc;
    clear_img();
    img[0] = 8'h85; img[1] = 8'h1F; img[15] = 8'h33;
    boot(); run(cyc);
    check("R9 taken pc", dbg_pc, 6);
    check("R9 taken ac", dbg_ac, 0);
    check("R9 jmz clocks", cyc, cost(8) + cost(0));
    clear_img();
    img[0] = 8'h1F; img[1] = 8'h85; img[15] = 8'h01;
    boot(); run(cyc);
    check("R9 not taken pc", dbg_pc, 3);
    check("R9 not taken ac", dbg_ac, 1);
  endtask

  task automatic t_nop();
    int cyc;
    clear_img();
    img[0] = 8'h9F; img[1] = 8'hF3; img[2] = 8'h1E; img[14] = 8'h42;
    img[15] = 8'h11;
    boot(); run(cyc);
    check("R11 nop leaves ac", dbg_ac, 8'h42);
    check("R11 nop pc", dbg_pc, 4);
    check("R11 nop clocks", cyc, cost(9)*2 + cost(1) + cost(0));
  endtask

  task automatic t_wrap();
    int cyc;
    clear_img();
    img[0] = 8'h7F; img[15] = 8'h30;
    boot(); run(cyc);
    check("R12 pc wrapped to 0 then halted", dbg_pc, 1);
    check("R12 ac after wrap", dbg_ac, 8'h0F);
    check("R12 wrap clocks", cyc, cost(7) + cost(3) + cost(0));
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog R10: actual no finish expected finish");
    finish_run();
  end

  initial begin
    t_reset();
    t_lda_timing();
    t_lda_add_sta();
    t_add_wrap();
    t_sub_order();
    t_ldi();
    t_sti();
    t_jmp();
    t_jmz();
    t_nop();
    t_wrap();
    finish_run();
  end
endmodule